// File: doc/BRIEF.md
# Linked-Descriptor Fetch DMA

This block pulls data words out of memory and hands them, one 32-bit beat at a time, to downstream processing engines through a small output FIFO. It has two modes, picked when a run is launched. In direct mode it reads one contiguous buffer, taking the length and routing tag from configuration inputs. In indirect mode it follows a chain of four-word descriptors in memory. Each descriptor names a data block, its byte length, a routing tag and the address of the next descriptor. A next-pointer value of 1 ends the chain.

The memory side is a plain valid/ready request port with a one-word response that can flag an error. Only one request is outstanding at a time. The stream side carries data, byte enables, the block's tag and an end-of-block flag. Three sticky interrupt causes are kept: block end, stopped and bus error. Each cause has an enable. A soft reset input aborts any run, empties the FIFO and clears the raw causes.

Top module: `sg_fetch_dma`

## Requirements
- R1: In indirect mode a descriptor is read as four words at increasing addresses from its base. Offset +0 is the data block address, +4 the next-descriptor pointer, +8 the length word and +12 the tag.
- R2: When the next-pointer equals 1, the engine stops after the current block. Any other value is used as the base of the next descriptor.
- R3: The byte count is bits [28:0] of the length word. A block produces ceil(count/4) beats, read from consecutive word addresses starting at the block address, with bytes packed little-endian.
- R4: Every beat except the last of a block has byte enables 4'hF. A partial last beat enables only its low count mod 4 bytes. When length bit 29 (realign) is set, the last beat enables all four bytes.
- R5: Every beat carries its block's tag on `out_tag`. `out_last` is 1 on the final beat of each block and 0 on the others.
- R6: In direct mode the engine reads `cfg_direct_len` bytes from `cfg_start_addr` and tags them with `cfg_direct_tag`. No descriptor is read and no block-end cause is raised.
- R7: A descriptor whose byte count is 0 produces no beats, and the engine moves straight on to its next-pointer.
- R8: Raw cause bit 0 (block end) is set when the last beat of an indirect block is fetched and length bit 30 is set. Bit 1 (stopped) is set when a run ends. Bit 2 (bus error) is set by an error response.
- R9: An error response ends the run: causes 2 and 1 are set, busy falls, and the errored word is not emitted.
- R10: `irq` is the OR of raw causes ANDed with their enables. `int_en_set` sets enable bits and `int_en_clr` clears them; set wins when both hit the same bit. Writing 1s to `int_raw_clr` clears raw bits, but a new event in the same cycle wins.
- R11: A start pulse while busy is ignored.
- R12: While `cfg_soft_rst` is 1, and for one cycle after it falls, the engine is held idle: the FIFO is empty, raw causes are 0 and start is ignored. `soft_rst_busy` follows `cfg_soft_rst` one cycle later.
- R13: `busy` is 1 from the cycle after an accepted start until the run ends. `fifo_not_empty` is 1 whenever beats wait in the output FIFO.
- R14: No data word is requested while the FIFO is full. A stalled request holds its address. Beats leave in read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | AW | Buffer address (direct) or first descriptor address (indirect) |
| cfg_indirect | input | 1 | 1 selects descriptor-chain mode |
| cfg_direct_len | input | 32 | Length word for direct mode, same layout as the descriptor length |
| cfg_direct_tag | input | 32 | Tag used in direct mode |
| cfg_soft_rst | input | 1 | Soft reset level |
| start | input | 1 | Launch pulse |
| int_en_set | input | 3 | Enable-set strobes |
| int_en_clr | input | 3 | Enable-clear strobes |
| int_raw_clr | input | 3 | Write-one-to-clear strobes for raw causes |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_addr | output | AW | Byte address of requested word |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | 32 | Read data |
| rd_rsp_err | input | 1 | Response carries a bus error |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Downstream takes beat |
| out_data | output | 32 | Beat data |
| out_be | output | 4 | Byte enables |
| out_tag | output | 32 | Block routing tag |
| out_last | output | 1 | Final beat of block |
| busy | output | 1 | Run in progress |
| fifo_not_empty | output | 1 | Output FIFO holds beats |
| soft_rst_busy | output | 1 | Soft reset in progress |
| int_raw | output | 3 | Raw causes {error, stopped, block end} |
| irq | output | 1 | Enabled-cause interrupt |

## Verification
The bench uses the default parameters: a 32-bit address and a four-entry output FIFO. With only four entries, an eight-beat direct block with the sink stalled fills the FIFO. This exercises the full-FIFO request hold, the ignored restart and a soft reset that hits a stalled run. In the chained run the memory accepts a request only every other cycle. The 1 KiB bench memory is enough for a three-descriptor chain with a zero-length middle link, and for a fault injected on an address inside a block.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
    localparam int WORD_W      = 32;
    localparam int BE_W        = WORD_W / 8;
    localparam int LEN_W       = 29;
    localparam int REALIGN_BIT = 29;
    localparam int BLKIRQ_BIT  = 30;
    localparam int STOP_PTR    = 1;
    localparam int NIRQ        = 3;
    localparam int IRQ_BLK     = 0;
    localparam int IRQ_STOP    = 1;
    localparam int IRQ_ERR     = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_DREQ, S_DWAIT, S_SETUP, S_BREQ, S_BWAIT, S_NEXT
    } fsm_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] tag;
        logic              last;
    } beat_t;

    // Byte enables of a block's final beat.
    function automatic logic [BE_W-1:0] tail_be(input logic [1:0] rem, input logic realign);
        if (realign || rem == 2'd0) return '1;
        return (BE_W'(1) << rem) - BE_W'(1);
    endfunction
endpackage

// File: rtl/sgf_out_fifo.sv
module sgf_out_fifo #(
    parameter int W     = 69,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t q, d;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push) d.wp = wrap_inc(q.wp);
            if (pop)  d.rp = wrap_inc(q.rp);
            case ({push, pop})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[q.wp] <= push_data;
    end

    assign pop_data = mem_q[q.rp];
    assign empty    = (q.cnt == '0);
    assign full     = (q.cnt == CW'(DEPTH));

    // R14: the writer never pushes into a full FIFO
    p_no_overflow_r14: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R14: the reader never pops an empty FIFO
    p_no_underflow_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);
endmodule

// File: rtl/sgf_irq_regs.sv
module sgf_irq_regs
    import sgf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [NIRQ-1:0] ev,
    input  logic [NIRQ-1:0] en_set,
    input  logic [NIRQ-1:0] en_clr,
    input  logic [NIRQ-1:0] raw_clr,
    output logic [NIRQ-1:0] raw,
    output logic            irq
);
    typedef struct packed {
        logic [NIRQ-1:0] en;
        logic [NIRQ-1:0] raw;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d.en  = (q.en & ~en_clr) | en_set;
        d.raw = flush ? '0 : ((q.raw & ~raw_clr) | ev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw = q.raw;
    assign irq = |(q.raw & q.en);

    // R9: an error event leaves both error and stopped causes set
    p_err_sets_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[IRQ_ERR] && !flush) |=> (raw[IRQ_ERR] && raw[IRQ_STOP]));
    // R12: soft reset leaves no raw cause behind
    p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (raw == '0));
endmodule

// File: rtl/sg_fetch_dma.sv
module sg_fetch_dma
    import sgf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_start_addr,
    input  logic              cfg_indirect,
    input  logic [31:0]       cfg_direct_len,
    input  logic [31:0]       cfg_direct_tag,
    input  logic              cfg_soft_rst,
    input  logic              start,
    input  logic [2:0]        int_en_set,
    input  logic [2:0]        int_en_clr,
    input  logic [2:0]        int_raw_clr,
    output logic              rd_req_valid,
    output logic [AW-1:0]     rd_req_addr,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    input  logic              rd_rsp_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic [3:0]        out_be,
    output logic [31:0]       out_tag,
    output logic              out_last,
    output logic              busy,
    output logic              fifo_not_empty,
    output logic              soft_rst_busy,
    output logic [2:0]        int_raw,
    output logic              irq
);
    localparam int WC_W   = LEN_W - 1;
    localparam int BEAT_W = $bits(beat_t);

    typedef struct packed {
        fsm_e              st;
        logic [1:0]        widx;
        logic [AW-1:0]     dbase;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     nxt;
        logic [WORD_W-1:0] lenw;
        logic [WORD_W-1:0] tag;
        logic [WC_W-1:0]   left;
        logic              ind;
        logic              srst;
    } ctl_t;

    ctl_t q, d;

    logic            kill;
    logic            push;
    logic            fifo_full, fifo_empty, pop;
    logic [NIRQ-1:0] ev;
    beat_t           in_beat, out_beat;
    logic [LEN_W:0]  rnd;
    logic            last_word;

    assign kill      = cfg_soft_rst | q.srst;
    assign rnd       = {1'b0, q.lenw[LEN_W-1:0]} + (LEN_W + 1)'(3);
    assign last_word = (q.left == WC_W'(1));

    always_comb begin
        d            = q;
        d.srst       = cfg_soft_rst;
        rd_req_valid = 1'b0;
        rd_req_addr  = q.addr;
        push         = 1'b0;
        ev           = '0;

        case (q.st)
            S_IDLE: begin
                if (start && !kill) begin
                    d.ind = cfg_indirect;
                    if (cfg_indirect) begin
                        d.dbase = cfg_start_addr;
                        d.widx  = 2'd0;
                        d.st    = S_DREQ;
                    end else begin
                        d.addr = cfg_start_addr;
                        d.lenw = cfg_direct_len;
                        d.tag  = cfg_direct_tag;
                        d.nxt  = AW'(STOP_PTR);
                        d.st   = S_SETUP;
                    end
                end
            end
            S_DREQ: begin
                rd_req_valid = 1'b1;
                rd_req_addr  = q.dbase + AW'({q.widx, 2'b00});
                if (rd_req_ready) d.st = S_DWAIT;
            end
            S_DWAIT: begin
                if (rd_rsp_valid) begin
                    if (rd_rsp_err) begin
                        ev[IRQ_ERR]  = 1'b1;
                        ev[IRQ_STOP] = 1'b1;
                        d.st         = S_IDLE;
                    end else begin
                        case (q.widx)
                            2'd0:    d.addr = AW'(rd_rsp_data);
                            2'd1:    d.nxt  = AW'(rd_rsp_data);
                            2'd2:    d.lenw = rd_rsp_data;
                            default: d.tag  = rd_rsp_data;
                        endcase
                        if (q.widx == 2'd3) begin
                            d.st = S_SETUP;
                        end else begin
                            d.widx = q.widx + 2'd1;
                            d.st   = S_DREQ;
                        end
                    end
                end
            end
            S_SETUP: begin
                d.left = rnd[LEN_W:2];
                d.st   = (q.lenw[LEN_W-1:0] == '0) ? S_NEXT : S_BREQ;
            end
            S_BREQ: begin
                rd_req_valid = !fifo_full;
                rd_req_addr  = q.addr;
                if (!fifo_full && rd_req_ready) d.st = S_BWAIT;
            end
            S_BWAIT: begin
                if (rd_rsp_valid) begin
                    if (rd_rsp_err) begin
                        ev[IRQ_ERR]  = 1'b1;
                        ev[IRQ_STOP] = 1'b1;
                        d.st         = S_IDLE;
                    end else begin
                        push   = 1'b1;
                        d.addr = q.addr + AW'(BE_W);
                        d.left = q.left - WC_W'(1);
                        if (last_word) begin
                            ev[IRQ_BLK] = q.ind & q.lenw[BLKIRQ_BIT];
                            d.st        = S_NEXT;
                        end else begin
                            d.st = S_BREQ;
                        end
                    end
                end
            end
            S_NEXT: begin
                if (!q.ind || q.nxt == AW'(STOP_PTR)) begin
                    ev[IRQ_STOP] = 1'b1;
                    d.st         = S_IDLE;
                end else begin
                    d.dbase = q.nxt;
                    d.widx  = 2'd0;
                    d.st    = S_DREQ;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (kill) begin
            d.st         = S_IDLE;
            rd_req_valid = 1'b0;
            push         = 1'b0;
            ev           = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        in_beat.data = rd_rsp_data;
        in_beat.be   = last_word ? tail_be(q.lenw[1:0], q.lenw[REALIGN_BIT]) : '1;
        in_beat.tag  = q.tag;
        in_beat.last = last_word;
    end

    logic unused_len_top;
    assign unused_len_top = q.lenw[WORD_W-1];

    assign pop = out_ready && !fifo_empty;

    sgf_out_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (kill),
        .push      (push),
        .push_data (in_beat),
        .pop       (pop),
        .pop_data  (out_beat),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    sgf_irq_regs u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (kill),
        .ev      (ev),
        .en_set  (int_en_set),
        .en_clr  (int_en_clr),
        .raw_clr (int_raw_clr),
        .raw     (int_raw),
        .irq     (irq)
    );

    assign out_valid      = !fifo_empty;
    assign out_data       = out_beat.data;
    assign out_be         = out_beat.be;
    assign out_tag        = out_beat.tag;
    assign out_last       = out_beat.last;
    assign busy           = (q.st != S_IDLE);
    assign fifo_not_empty = !fifo_empty;
    assign soft_rst_busy  = q.srst;

    // R14: a stalled request keeps its address until taken
    p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=>
            ((rd_req_valid && $stable(rd_req_addr)) || cfg_soft_rst));
    // R9: an error response during a run ends it
    p_abort_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rsp_valid && rd_rsp_err && busy) |=> !busy);
    // R12: soft reset keeps the engine idle and the FIFO empty
    p_srst_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_busy |-> (!busy && !fifo_not_empty));
    // R4: only a block's final beat may have a partial byte enable
    p_body_full_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_be == 4'hF));
    // R13: requests only issue during a run
    p_req_only_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> busy);
endmodule

// File: tb/sg_fetch_dma_test.sv
`timescale 1ns/1ps
module sg_fetch_dma_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_start_addr;
    logic        cfg_indirect;
    logic [31:0] cfg_direct_len;
    logic [31:0] cfg_direct_tag;
    logic        cfg_soft_rst;
    logic        start;
    logic [2:0]  int_en_set, int_en_clr, int_raw_clr;
    logic        rd_req_valid;
    logic [31:0] rd_req_addr;
    logic        mem_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        out_valid, out_ready;
    logic [31:0] out_data, out_tag;
    logic [3:0]  out_be;
    logic        out_last, busy, fifo_not_empty, soft_rst_busy, irq;
    logic [2:0]  int_raw;

    always #2 clk = ~clk;

    sg_fetch_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr),
        .cfg_indirect(cfg_indirect), .cfg_direct_len(cfg_direct_len),
        .cfg_direct_tag(cfg_direct_tag), .cfg_soft_rst(cfg_soft_rst), .start(start),
        .int_en_set(int_en_set), .int_en_clr(int_en_clr), .int_raw_clr(int_raw_clr),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(mem_ready),
        .rd_rsp_valid(rsp_valid), .rd_rsp_data(rsp_data), .rd_rsp_err(rsp_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_be(out_be),
        .out_tag(out_tag), .out_last(out_last), .busy(busy), .fifo_not_empty(fifo_not_empty),
        .soft_rst_busy(soft_rst_busy), .int_raw(int_raw), .irq(irq)
    );

    // memory model: 256 words, response one cycle after acceptance
    logic [31:0] mem [256];
    logic [31:0] err_addr;
    logic        slow_mem;
    always @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            mem_ready <= 1'b1;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (rd_req_valid && mem_ready) begin
                rsp_valid <= 1'b1;
                rsp_data  <= mem[rd_req_addr[9:2]];
                rsp_err   <= (rd_req_addr == err_addr);
            end
            mem_ready <= slow_mem ? ~mem_ready : 1'b1;
        end
    end

    // stream sink capture
    logic [31:0] cap_data [16];
    logic [31:0] cap_tag  [16];
    logic [3:0]  cap_be   [16];
    logic        cap_last [16];
    int          ncap;
    logic        cap_clr;
    always @(posedge clk) begin
        if (cap_clr) ncap <= 0;
        else if (out_valid && out_ready && ncap < 16) begin
            cap_data[ncap] <= out_data;
            cap_tag[ncap]  <= out_tag;
            cap_be[ncap]   <= out_be;
            cap_last[ncap] <= out_last;
            ncap <= ncap + 1;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic clear_cap();
        @(negedge clk) cap_clr = 1'b1;
        @(negedge clk) cap_clr = 1'b0;
    endtask

    task automatic clear_raw();
        @(negedge clk) int_raw_clr = 3'b111;
        @(negedge clk) int_raw_clr = 3'b000;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy && !fifo_not_empty) break;
        end
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic        ind;
        logic [31:0] lenw;
        logic [31:0] tag;
        logic [4:0]  beats;
        logic [3:0]  lbe;
        logic        birq;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{1'b0, 32'h0000_0008, 32'h21, 5'd2, 4'hF, 1'b0},
        '{1'b0, 32'h0000_0005, 32'h22, 5'd2, 4'h1, 1'b0},
        '{1'b1, 32'h0000_0007, 32'h11, 5'd2, 4'h7, 1'b0},
        '{1'b1, 32'h2000_0006, 32'h12, 5'd2, 4'hF, 1'b0},
        '{1'b1, 32'h4000_0004, 32'h13, 5'd1, 4'hF, 1'b1},
        '{1'b1, 32'h6000_0003, 32'h14, 5'd1, 4'hF, 1'b1},
        '{1'b0, 32'h4000_0002, 32'h23, 5'd1, 4'h3, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | i;
        rst_n = 1'b0; cfg_start_addr = '0; cfg_indirect = 1'b0; cfg_direct_len = '0;
        cfg_direct_tag = '0; cfg_soft_rst = 1'b0; start = 1'b0; int_en_set = '0;
        int_en_clr = '0; int_raw_clr = '0; out_ready = 1'b1; err_addr = 32'hFFFF_FFFF;
        slow_mem = 1'b0; cap_clr = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk) cap_clr = 1'b0;

        // reset state
        chk("R13 reset busy", busy, 0);
        chk("R13 reset fifo_not_empty", fifo_not_empty, 0);
        chk("R8 reset raw", int_raw, 0);
        chk("R10 reset irq", irq, 0);
        chk("R12 reset soft_rst_busy", soft_rst_busy, 0);

        // table walk
        foreach (TBL[r]) begin
            clear_cap();
            cfg_indirect = TBL[r].ind;
            if (TBL[r].ind) begin
                mem[64] = 32'h200; mem[65] = 32'h1; mem[66] = TBL[r].lenw; mem[67] = TBL[r].tag;
                cfg_start_addr = 32'h100;
            end else begin
                cfg_start_addr = 32'h200; cfg_direct_len = TBL[r].lenw; cfg_direct_tag = TBL[r].tag;
            end
            pulse_start();
            wait_done();
            chk(TBL[r].ind ? "R3 beat count" : "R6 direct beat count", ncap, TBL[r].beats);
            for (int k = 0; k < int'(TBL[r].beats); k++) begin
                chk("R3 data", cap_data[k], 32'hD000_0080 + k);
                chk("R5 tag", cap_tag[k], TBL[r].tag);
                chk("R4 be", cap_be[k], (k == int'(TBL[r].beats) - 1) ? TBL[r].lbe : 4'hF);
                chk("R5 last", cap_last[k], k == int'(TBL[r].beats) - 1);
            end
            chk(TBL[r].ind ? "R8 raw causes" : "R6 raw causes", int_raw, {1'b0, 1'b1, TBL[r].birq});
            clear_raw();
        end

        // R1 R2 R7: three-link chain with zero-length middle, slow memory
        slow_mem = 1'b1;
        clear_cap();
        mem[64] = 32'h200; mem[65] = 32'h140; mem[66] = 32'h5;         mem[67] = 32'hA;
        mem[80] = 32'h240; mem[81] = 32'h180; mem[82] = 32'h4000_0000; mem[83] = 32'hB;
        mem[96] = 32'h280; mem[97] = 32'h1;   mem[98] = 32'h4;         mem[99] = 32'hC;
        cfg_indirect = 1'b1; cfg_start_addr = 32'h100;
        pulse_start();
        wait_done();
        chk("R7 chain beat count", ncap, 3);
        chk("R1 first block data", cap_data[0], 32'hD000_0080);
        chk("R1 first block tag", cap_tag[1], 32'hA);
        chk("R4 partial be", cap_be[1], 4'h1);
        chk("R2 third block data", cap_data[2], 32'hD000_00A0);
        chk("R2 third block tag", cap_tag[2], 32'hC);
        chk("R5 third block last", cap_last[2], 1);
        chk("R7 no block-end cause", int_raw, 3'b010);
        clear_raw();
        slow_mem = 1'b0;

        // R9: error on second data word of a direct block
        clear_cap();
        err_addr = 32'h204; cfg_indirect = 1'b0; cfg_start_addr = 32'h200;
        cfg_direct_len = 32'd12; cfg_direct_tag = 32'h5;
        pulse_start();
        wait_done();
        chk("R9 beats before error", ncap, 1);
        chk("R9 raw causes", int_raw, 3'b110);
        chk("R9 busy", busy, 0);
        err_addr = 32'hFFFF_FFFF;

        // R10: enables and raw clear
        @(negedge clk) int_en_set = 3'b100;
        @(negedge clk) int_en_set = 3'b000;
        chk("R10 irq enabled error", irq, 1);
        int_en_clr = 3'b100;
        @(negedge clk) int_en_clr = 3'b000;
        chk("R10 irq disabled", irq, 0);
        int_en_set = 3'b010;
        @(negedge clk) int_en_set = 3'b000;
        chk("R10 irq stopped enabled", irq, 1);
        int_raw_clr = 3'b010;
        @(negedge clk) int_raw_clr = 3'b000;
        chk("R10 raw after clear", int_raw, 3'b100);
        chk("R10 irq after clear", irq, 0);
        clear_raw();

        // R14 R11 R13: backpressure fills the FIFO, restart ignored
        clear_cap();
        out_ready = 1'b0; cfg_start_addr = 32'h200; cfg_direct_len = 32'd32; cfg_direct_tag = 32'h7;
        pulse_start();
        repeat (30) @(negedge clk);
        chk("R14 busy while stalled", busy, 1);
        chk("R13 fifo_not_empty", fifo_not_empty, 1);
        chk("R14 nothing taken", ncap, 0);
        cfg_start_addr = 32'h280; cfg_direct_len = 32'd4;
        pulse_start();
        repeat (5) @(negedge clk);
        out_ready = 1'b1;
        wait_done();
        chk("R11 beat count", ncap, 8);
        for (int k = 0; k < 8; k++) chk("R14 order", cap_data[k], 32'hD000_0080 + k);

        // R12: soft reset of a stalled run
        out_ready = 1'b0; cfg_start_addr = 32'h200; cfg_direct_len = 32'd32;
        pulse_start();
        repeat (20) @(negedge clk);
        cfg_soft_rst = 1'b1;
        @(negedge clk);
        chk("R12 soft_rst_busy", soft_rst_busy, 1);
        chk("R12 busy", busy, 0);
        chk("R12 fifo emptied", fifo_not_empty, 0);
        chk("R12 raw cleared", int_raw, 0);
        pulse_start();
        chk("R12 start ignored", busy, 0);
        cfg_soft_rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R12 soft_rst_busy cleared", soft_rst_busy, 0);
        out_ready = 1'b1;
        clear_cap();
        cfg_direct_len = 32'd4;
        pulse_start();
        wait_done();
        chk("R12 run after soft reset", ncap, 1);
        chk("R12 data after soft reset", cap_data[0], 32'hD000_0080);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule